// File: doc/BRIEF.md
# Serial Timekeeper Register Access Master

This block reads and writes 32-bit registers that sit behind a slow three-wire serial port with a separate ready line, as found in an always-on timekeeping domain. The host hands over one request: a 3-bit register index, a direction flag and, for a write, a 32-bit word. The block then runs the whole serial exchange on its own. It idles the lines and polls the slave's ready line. It raises the enable line and clocks the frame out bit by bit. On a read it clocks the reply back in. It ends with a one-cycle completion pulse that carries an error flag and, for reads, the received word. In the timekeeping domain, index 0 is the seconds counter and index 1 is the general-purpose output control word. The block treats all eight indices the same way.

Requests use a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on the first clock edge where `req_valid` and `req_ready` are both high. From the next cycle until the completion pulse, `req_ready` stays low, so an upstream source must hold its request or retry it. A `req_valid` pulse that ends while `req_ready` is low is dropped. The response side has no back-pressure. `rsp_done` is high for exactly one cycle, and `rsp_error` and `rsp_rdata` are valid in that cycle and hold until the next completion. The serial timing is set in system-clock cycles: `HALF_CYC` is the clock half-period, `POLL_GAP` is the spacing between ready checks, and `POLL_TRIES` is the number of checks made before giving up.

Top module: `ssm_master`

## Requirements
- R1: After reset, and whenever the block is idle, `ser_clk`, `ser_en` and `ser_din` are low, `req_ready` is high and `rsp_done` is low.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high. In the following cycle `req_ready` is low, and a `req_valid` pulse made while `req_ready` is low starts no transfer and changes no frame.
- R3: After acceptance, the slave ready line (passed through a two-flop synchronizer) is checked every `POLL_GAP` cycles, for at most `POLL_TRIES` checks. `ser_en` never rises while the slave's ready input is low.
- R4: If no check sees ready, the block issues no `ser_clk` pulse and never raises `ser_en`. It completes with `rsp_error`=1, and `rsp_done` appears exactly `POLL_TRIES*POLL_GAP+1` cycles after the accepting edge.
- R5: `ser_en` rises, while `ser_clk` is low, on the check that sees ready. It stays high up to, but not including, the pulse that carries the direction bit. It is low during that pulse and stays low after it.
- R6: Every bit is one pulse. `ser_din` is set, `ser_clk` stays low for `HALF_CYC` cycles, then high for `HALF_CYC` cycles, and `ser_din` is stable while `ser_clk` is high.
- R7: The address field is 4 bits sent most significant bit first: the 3-bit index, then a direction bit that is 0 for a read and 1 for a write.
- R8: A write issues 36 pulses: the 32 data bits most significant bit first, then the address field.
- R9: A read issues 36 pulses: the address field, then 32 pulses with `ser_din` low. `ser_dout` is captured as each of those 32 pulses ends, most significant bit first, and appears on `rsp_rdata` with `rsp_done`.
- R10: `rsp_done` lasts exactly one cycle. A successful transfer reports `rsp_error`=0, even when the previous transfer timed out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_index | input | IDX_W | Register index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Word to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Ready timeout on the last completion |
| rsp_rdata | output | DATA_W | Word received by the last successful read |
| ser_clk | output | 1 | Serial clock |
| ser_en | output | 1 | Serial cycle enable |
| ser_din | output | 1 | Serial data toward the slave |
| ser_dout | input | 1 | Serial data from the slave |
| ser_rdy | input | 1 | Slave ready, asynchronous |

## Verification
Every index is run in both directions with distinct computed data words. Because each word differs from the others, a swapped field, a reversed bit order or a misplaced enable drop shows up as a frame mismatch rather than being masked by a symmetric pattern. The delay before ready rises is varied per transfer: an early ready tests the synchronizer and the rule that enable waits for ready, and a ready near the last check tests the poll count. A ready that never rises separates the exact timeout cadence and the absence of clocks from a transfer that merely ran late. A request injected mid-transfer shows whether acceptance is gated, and a success right after a timeout shows whether the error flag clears.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_LOW,
    ST_HIGH,
    ST_FIN
  } ssm_state_t;
endpackage

// File: rtl/ssm_sync.sv
module ssm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/ssm_timer.sv
module ssm_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             expired
);
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ssm_frame.sv
module ssm_frame #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_write,
  input  logic [IDX_W-1:0]  load_index,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  input  logic              capture,
  input  logic              cap_bit,
  output logic              head,
  output logic [DATA_W-1:0] rx_word
);
  localparam int FRAME_W = DATA_W + IDX_W + 1;

  logic [FRAME_W-1:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_word <= '0;
    end else if (load) begin
      if (load_write) tx_sr <= {load_data, load_index, 1'b1};
      else            tx_sr <= {load_index, 1'b0, {DATA_W{1'b0}}};
      rx_word <= '0;
    end else begin
      if (shift)   tx_sr   <= {tx_sr[FRAME_W-2:0], 1'b0};
      if (capture) rx_word <= {rx_word[DATA_W-2:0], cap_bit};
    end
  end

  assign head = tx_sr[FRAME_W-1];
endmodule

// File: rtl/ssm_master.sv
module ssm_master #(
  parameter int HALF_CYC   = 1250,
  parameter int POLL_GAP   = 1250,
  parameter int POLL_TRIES = 40,
  parameter int IDX_W      = 3,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_index,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ser_clk,
  output logic              ser_en,
  output logic              ser_din,
  input  logic              ser_dout,
  input  logic              ser_rdy
);
  import ssm_pkg::*;

  localparam int ADDR_W  = IDX_W + 1;
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int BIT_W   = $clog2(FRAME_W + 1);
  localparam int TRY_W   = $clog2(POLL_TRIES + 1);
  localparam int TMR_MAX = (HALF_CYC > POLL_GAP) ? HALF_CYC : POLL_GAP;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  ssm_state_t       state;
  logic [BIT_W-1:0] bitn;
  logic [TRY_W-1:0] tries;
  logic             wr_q;
  logic             fail_q;

  logic             rdy_s;
  logic             tmr_zero;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             head;
  logic [DATA_W-1:0] rx_word;

  logic accept, poll_hit, poll_miss, give_up, low_end, high_end, last_bit;
  logic do_shift, do_capture;
  logic [BIT_W-1:0] drop_idx;

  ssm_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ser_rdy), .q_sync(rdy_s)
  );

  ssm_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_zero)
  );

  ssm_frame #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_write(req_write),
    .load_index(req_index), .load_data(req_wdata), .shift(do_shift),
    .capture(do_capture), .cap_bit(ser_dout), .head(head), .rx_word(rx_word)
  );

  assign req_ready = (state == ST_IDLE);

  always_comb begin
    accept     = (state == ST_IDLE) && req_valid;
    poll_hit   = (state == ST_POLL) && tmr_zero && rdy_s;
    poll_miss  = (state == ST_POLL) && tmr_zero && !rdy_s;
    give_up    = poll_miss && (tries == TRY_W'(POLL_TRIES - 1));
    low_end    = (state == ST_LOW) && tmr_zero;
    high_end   = (state == ST_HIGH) && tmr_zero;
    last_bit   = (bitn == BIT_W'(FRAME_W - 1));
    drop_idx   = wr_q ? BIT_W'(FRAME_W - 1) : BIT_W'(ADDR_W - 1);
    tmr_load   = accept || (poll_miss && !give_up) || poll_hit || low_end ||
                 (high_end && !last_bit);
    tmr_val    = (accept || poll_miss) ? TMR_W'(POLL_GAP - 1)
                                       : TMR_W'(HALF_CYC - 1);
    do_shift   = poll_hit || (high_end && !last_bit);
    do_capture = high_end && !wr_q && (bitn >= BIT_W'(ADDR_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitn      <= '0;
      tries     <= '0;
      wr_q      <= 1'b0;
      fail_q    <= 1'b0;
      ser_clk   <= 1'b0;
      ser_en    <= 1'b0;
      ser_din   <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            wr_q   <= req_write;
            tries  <= '0;
            fail_q <= 1'b0;
            state  <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (poll_hit) begin
            ser_en  <= 1'b1;
            ser_din <= head;
            bitn    <= '0;
            state   <= ST_LOW;
          end else if (give_up) begin
            fail_q <= 1'b1;
            state  <= ST_FIN;
          end else if (poll_miss) begin
            tries <= tries + 1'b1;
          end
        end
        ST_LOW: begin
          if (low_end) begin
            ser_clk <= 1'b1;
            state   <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (high_end) begin
            ser_clk <= 1'b0;
            if (last_bit) begin
              state <= ST_FIN;
            end else begin
              bitn    <= bitn + 1'b1;
              ser_din <= head;
              if (bitn + 1'b1 == drop_idx) ser_en <= 1'b0;
              state   <= ST_LOW;
            end
          end
        end
        ST_FIN: begin
          rsp_done  <= 1'b1;
          rsp_error <= fail_q;
          ser_din   <= 1'b0;
          ser_en    <= 1'b0;
          if (!fail_q && !wr_q) rsp_rdata <= rx_word;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ssm_master_chk.sv
module ssm_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_done,
  input logic rsp_error,
  input logic ser_clk,
  input logic ser_en,
  input logic ser_din
);
  logic       clk_d;
  logic [7:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d <= 1'b0;
      rises <= '0;
    end else begin
      clk_d <= ser_clk;
      if (req_valid && req_ready)              rises <= '0;
      else if (ser_clk && !clk_d && rises != 8'hff) rises <= rises + 1'b1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ser_clk && !ser_en));

  // R2
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R4
  timeout_noclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_error) |-> (rises == 8'd0));

  // R5
  en_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_en) |-> !ser_clk);

  // R6
  din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_din));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind ssm_master ssm_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .rsp_error(rsp_error), .ser_clk(ser_clk),
  .ser_en(ser_en), .ser_din(ser_din)
);

// File: tb/ssm_master_bench.sv
`timescale 1ns/1ps
module ssm_master_bench;
  localparam int H = 3;
  localparam int G = 4;
  localparam int T = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_index = '0;
  logic req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic rsp_done, rsp_error;
  logic [31:0] rsp_rdata;
  logic ser_clk, ser_en, ser_din;
  logic ser_dout = 1'b0;
  logic ser_rdy = 1'b0;

  int errors = 0;
  int checks = 0;

  // slave-side monitor state
  logic        prev_clk = 1'b0;
  int          npulse = 0;
  logic [35:0] dinv = '0;
  logic [35:0] env = '0;
  logic        en_seen = 1'b0;
  logic        en_early = 1'b0;
  logic        hi_bad = 1'b0;
  int          hcnt = 0;
  int          cyc = 0;
  int          done_cnt = 0;
  logic [31:0] slave_word = '0;

  always #2 clk = ~clk;

  ssm_master #(.HALF_CYC(H), .POLL_GAP(G), .POLL_TRIES(T)) u_ssm_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .ser_clk(ser_clk), .ser_en(ser_en), .ser_din(ser_din),
    .ser_dout(ser_dout), .ser_rdy(ser_rdy)
  );

  always @(posedge clk) begin
    prev_clk <= ser_clk;
    if (rsp_done) done_cnt <= done_cnt + 1;
    if (req_valid && req_ready) begin
      npulse <= 0; dinv <= '0; env <= '0; en_seen <= 1'b0;
      en_early <= 1'b0; hi_bad <= 1'b0; hcnt <= 0; cyc <= 0;
    end else begin
      cyc <= cyc + 1;
      if (ser_en) en_seen <= 1'b1;
      if (ser_en && !en_seen && !ser_rdy) en_early <= 1'b1;
      if (ser_clk && !prev_clk) begin
        dinv <= {dinv[34:0], ser_din};
        env  <= {env[34:0], ser_en};
        if (npulse >= 4 && npulse <= 35) ser_dout <= slave_word[35-npulse];
        npulse <= npulse + 1;
      end
      if (ser_clk) hcnt <= hcnt + 1;
      else if (prev_clk) begin
        if (hcnt != H) hi_bad <= 1'b1;
        hcnt <= 0;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'h9E3779B9 * (i + 1)) ^ (32'(i) << 27) ^ 32'h00F0_0F00;
  endfunction

  task automatic wait_done(output int n);
    n = 0;
    while (!rsp_done && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic xfer(input int idx, input logic wr, input logic [31:0] wd,
                      input logic [31:0] sw, input int d, input logic inject);
    int n;
    int dc0;
    logic [35:0] exp_f;
    logic [35:0] exp_e;
    @(negedge clk);
    ser_rdy = 1'b0; slave_word = sw;
    req_index = 3'(idx); req_write = wr; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    dc0 = done_cnt;
    repeat (d) @(negedge clk);
    ser_rdy = 1'b1;
    if (inject) begin
      repeat (20) @(negedge clk);
      req_index = 3'(idx + 3); req_write = !wr; req_wdata = ~wd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait_done(n);
    exp_f = wr ? {wd, 3'(idx), 1'b1} : {3'(idx), 1'b0, 32'h0};
    exp_e = wr ? 36'hF_FFFF_FFFE : {3'b111, 33'h0};
    chk(rsp_done, "R10 done seen", 64'(rsp_done), 1);
    chk(npulse == 36, wr ? "R8 pulse count" : "R9 pulse count", 64'(npulse), 36);
    chk(dinv == exp_f, wr ? "R8 R7 write frame" : "R7 R9 read frame", 64'(dinv), 64'(exp_f));
    chk(env == exp_e, "R5 enable per pulse", 64'(env), 64'(exp_e));
    chk(!en_early, "R3 enable waits for ready", 64'(en_early), 0);
    chk(!hi_bad, "R6 high phase width", 64'(hi_bad), 0);
    chk(rsp_error == 1'b0, "R10 no error on success", 64'(rsp_error), 0);
    if (!wr) chk(rsp_rdata == sw, "R9 read data", 64'(rsp_rdata), 64'(sw));
    @(negedge clk);
    chk(!rsp_done, "R10 done one cycle", 64'(rsp_done), 0);
    chk(req_ready && !ser_en && !ser_clk, "R1 idle after done",
        64'({req_ready, ser_en, ser_clk}), 64'(3'b100));
    if (inject) begin
      repeat (200) @(negedge clk);
      chk(done_cnt == dc0 + 1, "R2 request while busy ignored", 64'(done_cnt - dc0), 1);
      chk(npulse == 36, "R2 no extra pulses", 64'(npulse), 36);
    end
    ser_rdy = 1'b0;
  endtask

  task automatic timeout_case;
    int n;
    @(negedge clk);
    ser_rdy = 1'b0; req_index = 3'd1; req_write = 1'b1;
    req_wdata = 32'h0050_0000; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(n);
    chk(rsp_done && rsp_error, "R4 timeout error", 64'({rsp_done, rsp_error}), 3);
    chk(npulse == 0, "R4 no clocks on timeout", 64'(npulse), 0);
    chk(!en_seen, "R4 enable never raised", 64'(en_seen), 0);
    chk(cyc == T * G + 1, "R3 R4 poll cadence", 64'(cyc), 64'(T * G + 1));
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    chk(!ser_clk && !ser_en && !ser_din, "R1 lines low in reset",
        64'({ser_clk, ser_en, ser_din}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_done, "R1 ready after reset", 64'({req_ready, rsp_done}), 2);
    for (int i = 0; i < 16; i++) begin
      xfer(i % 8, logic'(i / 8), pat(i), pat(i + 40), (i * 7) % 60, 1'b0);
    end
    xfer(0, 1'b0, 32'h0, 32'hFFFF_FFFF, 0, 1'b0);
    xfer(7, 1'b1, 32'h8000_0001, 32'h0, 0, 1'b0);
    xfer(1, 1'b0, 32'h0, 32'h0000_0001, T * G - 8, 1'b0);
    xfer(2, 1'b1, 32'h1234_5678, 32'h0, 5, 1'b1);
    timeout_case();
    xfer(0, 1'b0, 32'h0, 32'h6A5F_0C31, 3, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule